// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a serial memory front end and a storage array. After the front end has decoded the start of a write and its target address, the block gathers the data bytes of that write into a small page buffer. Each byte is acknowledged or refused as it arrives. When the front end reports the end of the write, the block copies the gathered bytes into the array and then holds a busy flag for a fixed number of clocks. This models a self-timed programming interval.

The address pointer moves only inside one page, so a long burst wraps around and overwrites earlier bytes. Only slots that actually received a byte are copied into the array. An optional protect input makes the upper half of the address space read-only. A protected write is refused at its first data byte. An address-only transaction, which carries no data bytes, never starts a busy interval. The pointer output lets the surrounding controller keep its shared address pointer in step with the block.

Top module: `page_commit_top`

## Requirements
- R1: After reset, `busy`, `byte_ack` and `arr_we` are low and `ptr_out` is zero.
- R2: A data byte that is accepted raises `byte_ack` in the clock cycle after its `byte_vld` cycle. `byte_ack` is low in every other cycle.
- R3: Each accepted byte advances only the low log2(PAGE_BYTES) bits of `ptr_out`, modulo the page size. The upper bits keep the page set by `start_addr`, and `ptr_out` shows the next free location.
- R4: When more than PAGE_BYTES bytes arrive before the end of the write, the pointer wraps. The array then holds the byte received last for each slot.
- R5: `stop_evt` on a write that stored at least one byte raises `busy` in the next cycle. `busy` then stays high for exactly TWR_CYCLES cycles.
- R6: During `busy`, the array receives exactly one write for each filled slot. Each write goes to the page address with that slot's index in the low bits, and no array write happens outside `busy`.
- R7: When `wp` is high and `ptr_out` bit ADDR_W-1 is 1, a data byte is refused: `byte_ack` stays low. From that point the whole write is refused, nothing reaches the array and `busy` stays low.
- R8: When `wp` is low, upper-half addresses are written like lower-half ones.
- R9: A write that ends with no data bytes leaves `busy` low and performs no array write.
- R10: While `busy` is high, `txn_start`, `byte_vld` and `stop_evt` have no effect: no acknowledge is given and `ptr_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | Opens a write at `start_addr` |
| start_addr | input | ADDR_W | Array address of the first data byte |
| byte_vld | input | 1 | One-cycle strobe for a data byte |
| byte_data | input | DATA_W | Data byte |
| stop_evt | input | 1 | End of the current write |
| wp | input | 1 | Protect the upper half when high |
| byte_ack | output | 1 | Acknowledge for the previous cycle's byte |
| busy | output | 1 | Commit and timed interval in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| ptr_out | output | ADDR_W | Current address pointer |

## Verification
The assertions assume that each strobe (`txn_start`, `byte_vld`, `stop_evt`) lasts one cycle and that no two strobes occur in the same cycle. They also assume that `wp` stays steady for the whole of a write. The bench drives every strobe on the falling edge for a single cycle, with idle cycles in between, and changes `wp` only between writes. Its sweep covers both halves of the address space, both settings of `wp`, every start slot, and burst lengths of zero, one, a partial page, a full page and an over-full page. One directed case issues strobes during `busy` and checks that they are ignored.

// File: rtl/page_commit_pkg.sv
`timescale 1ns/1ps
package page_commit_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SCAN = 2'd1,
      PH_HOLD = 2'd2
   } commit_ph_e;
endpackage

// File: rtl/page_store.sv
`timescale 1ns/1ps
module page_store #(
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 16,
   localparam int SLOT_W    = $clog2(PAGE_BYTES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  wr_en,
   input  logic [SLOT_W-1:0]     wr_slot,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [SLOT_W-1:0]     rd_slot,
   output logic [DATA_W-1:0]     rd_data,
   output logic [PAGE_BYTES-1:0] fill_mask
);
   logic [DATA_W-1:0] slot_data [PAGE_BYTES];

   generate
      for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
         logic [DATA_W-1:0] d_q;
         logic              v_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d_q <= '0;
               v_q <= 1'b0;
            end else if (clr) begin
               v_q <= 1'b0;
            end else if (wr_en && (wr_slot == SLOT_W'(g))) begin
               d_q <= wr_data;
               v_q <= 1'b1;
            end
         end
         assign slot_data[g] = d_q;
         assign fill_mask[g] = v_q;
      end
   endgenerate

   assign rd_data = slot_data[rd_slot];
endmodule

// File: rtl/commit_seq.sv
`timescale 1ns/1ps
module commit_seq
   import page_commit_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 16,
   parameter int TWR_CYCLES = 64,
   localparam int SLOT_W    = $clog2(PAGE_BYTES),
   localparam int HI_W      = ADDR_W - SLOT_W,
   localparam int CNT_W     = $clog2(TWR_CYCLES + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go,
   input  logic [PAGE_BYTES-1:0] fill_mask,
   input  logic [HI_W-1:0]       page_hi,
   input  logic [DATA_W-1:0]     rd_data,
   output logic [SLOT_W-1:0]     rd_slot,
   output logic                  busy,
   output logic                  arr_we,
   output logic [ADDR_W-1:0]     arr_addr,
   output logic [DATA_W-1:0]     arr_wdata
);
   commit_ph_e        ph_q;
   logic [SLOT_W-1:0] idx_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q      <= PH_IDLE;
         idx_q     <= '0;
         cnt_q     <= '0;
         arr_we    <= 1'b0;
         arr_addr  <= '0;
         arr_wdata <= '0;
      end else begin
         arr_we <= 1'b0;
         case (ph_q)
            PH_IDLE: begin
               if (go) begin
                  ph_q  <= PH_SCAN;
                  idx_q <= '0;
                  cnt_q <= '0;
               end
            end
            PH_SCAN: begin
               cnt_q     <= cnt_q + 1'b1;
               arr_we    <= fill_mask[idx_q];
               arr_addr  <= {page_hi, idx_q};
               arr_wdata <= rd_data;
               idx_q     <= idx_q + 1'b1;
               if (idx_q == SLOT_W'(PAGE_BYTES - 1)) ph_q <= PH_HOLD;
            end
            PH_HOLD: begin
               if (cnt_q == CNT_W'(TWR_CYCLES - 1)) ph_q <= PH_IDLE;
               else cnt_q <= cnt_q + 1'b1;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign rd_slot = idx_q;
   assign busy    = (ph_q != PH_IDLE);
endmodule

// File: rtl/page_commit_top.sv
`timescale 1ns/1ps
module page_commit_top #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 16,
   parameter int TWR_CYCLES = 64,
   parameter bit WP_ENABLE  = 1'b1,
   localparam int SLOT_W    = $clog2(PAGE_BYTES),
   localparam int HI_W      = ADDR_W - SLOT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              txn_start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              stop_evt,
   input  logic              wp,
   output logic              byte_ack,
   output logic              busy,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_wdata,
   output logic [ADDR_W-1:0] ptr_out
);
   generate
      if ((1 << SLOT_W) != PAGE_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
      if (ADDR_W <= SLOT_W) begin : g_bad_addr
         $error("ADDR_W must exceed the page index width");
      end
      if (TWR_CYCLES < PAGE_BYTES + 1) begin : g_bad_twr
         $error("TWR_CYCLES must cover the slot scan");
      end
   endgenerate

   logic                  open_q, refused_q, ack_q;
   logic [ADDR_W-1:0]     ptr_q;
   logic                  refuse_now;
   logic                  take_start, take_byte, take_stop, store_en, commit_go;
   logic [PAGE_BYTES-1:0] fill_mask;
   logic [SLOT_W-1:0]     rd_slot;
   logic [DATA_W-1:0]     rd_data;

   generate
      if (WP_ENABLE) begin : g_wp
         assign refuse_now = refused_q || (wp && ptr_q[ADDR_W-1]);
      end else begin : g_nowp
         assign refuse_now = 1'b0;
      end
   endgenerate

   assign take_start = txn_start && !busy;
   assign take_byte  = byte_vld && open_q && !busy && !txn_start;
   assign take_stop  = stop_evt && open_q && !busy && !txn_start;
   assign store_en   = take_byte && !refuse_now;
   assign commit_go  = take_stop && !refused_q && (|fill_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q    <= 1'b0;
         refused_q <= 1'b0;
         ack_q     <= 1'b0;
         ptr_q     <= '0;
      end else begin
         ack_q <= store_en;
         if (take_start) begin
            open_q    <= 1'b1;
            refused_q <= 1'b0;
            ptr_q     <= start_addr;
         end else begin
            if (take_byte && refuse_now) refused_q <= 1'b1;
            if (store_en) ptr_q <= {ptr_q[ADDR_W-1:SLOT_W], ptr_q[SLOT_W-1:0] + 1'b1};
            if (take_stop) open_q <= 1'b0;
         end
      end
   end

   page_store #(
      .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .clr(take_start),
      .wr_en(store_en), .wr_slot(ptr_q[SLOT_W-1:0]), .wr_data(byte_data),
      .rd_slot(rd_slot), .rd_data(rd_data), .fill_mask(fill_mask)
   );

   commit_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .TWR_CYCLES(TWR_CYCLES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .go(commit_go), .fill_mask(fill_mask),
      .page_hi(ptr_q[ADDR_W-1:SLOT_W]), .rd_data(rd_data), .rd_slot(rd_slot),
      .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
   );

   assign byte_ack = ack_q;
   assign ptr_out  = ptr_q;
endmodule

// File: rtl/page_commit_chk.sv
`timescale 1ns/1ps
module page_commit_chk #(
   parameter int ADDR_W = 8,
   parameter int SLOT_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              byte_vld,
   input logic              stop_evt,
   input logic              wp,
   input logic              byte_ack,
   input logic              busy,
   input logic              arr_we,
   input logic [ADDR_W-1:0] arr_addr,
   input logic [ADDR_W-1:0] ptr_out
);
   assert_we_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy);
   assert_we_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> (arr_addr[ADDR_W-1:SLOT_W] == ptr_out[ADDR_W-1:SLOT_W]));
   assert_ack_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      byte_ack |-> $past(byte_vld));
   assert_busy_no_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && byte_vld) |=> !byte_ack);
   assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(ptr_out));
   assert_wp_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && wp && ptr_out[ADDR_W-1] && !busy) |=> !byte_ack);
   assert_busy_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_evt));
endmodule

bind page_commit_top page_commit_chk #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .stop_evt(stop_evt), .wp(wp),
   .byte_ack(byte_ack), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
   .ptr_out(ptr_out)
);

// File: tb/test_page_commit_top.sv
`timescale 1ns/1ps
module test_page_commit_top;
   localparam int AW = 8, DW = 8, PB = 16, TWR = 20;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n, txn_start, byte_vld, stop_evt, wp;
   logic [AW-1:0] start_addr, arr_addr, ptr_out;
   logic [DW-1:0] byte_data, arr_wdata;
   logic          byte_ack, busy, arr_we;

   page_commit_top #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .TWR_CYCLES(TWR)) i_page_commit_top (
      .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .start_addr(start_addr),
      .byte_vld(byte_vld), .byte_data(byte_data), .stop_evt(stop_evt), .wp(wp),
      .byte_ack(byte_ack), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
      .arr_wdata(arr_wdata), .ptr_out(ptr_out)
   );

   int n_chk = 0, n_bad = 0, wr_cnt = 0, txn_no = 0;
   bit done = 1'b0;
   logic [DW-1:0] exp_mem [256];
   logic [DW-1:0] got_mem [256];

   always @(negedge clk) if (arr_we) begin
      got_mem[arr_addr] = arr_wdata;
      wr_cnt++;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] dat(input int base, input int i, input int t);
      return 8'((base * 7 + i * 29 + t * 3 + 8'h5A) & 8'hFF);
   endfunction

   task automatic run_txn(input int page, input int slot, input int len, input bit wpv);
      int base = page * PB + slot;
      bit prot = wpv && (page >= 8);
      bit commit = !prot && (len > 0);
      int nexp = (len > PB) ? PB : len;
      int nb, bad;
      string rq = prot ? "R7" : ((page >= 8) ? "R8" : "R2");
      txn_no++;
      @(negedge clk); wp = wpv; txn_start = 1'b1; start_addr = AW'(base);
      @(negedge clk); txn_start = 1'b0;
      for (int i = 0; i < len; i++) begin
         byte_vld = 1'b1; byte_data = dat(base, i, txn_no);
         @(negedge clk); byte_vld = 1'b0;
         chk(rq, byte_ack, !prot);
         if (!prot) exp_mem[page * PB + ((slot + i) % PB)] = dat(base, i, txn_no);
         @(negedge clk);
      end
      wr_cnt = 0;
      stop_evt = 1'b1;
      @(negedge clk); stop_evt = 1'b0;
      chk(len == 0 ? "R9" : (prot ? "R7" : "R5"), busy, commit);
      chk("R3", ptr_out, prot ? base : page * PB + ((slot + len) % PB));
      nb = 0;
      while (busy && nb < 1000) begin nb++; @(negedge clk); end
      if (commit) chk("R5", nb, TWR);
      @(negedge clk);
      chk("R6", wr_cnt, commit ? nexp : 0);
      bad = 0;
      for (int a = 0; a < PB; a++)
         if (got_mem[page * PB + a] !== exp_mem[page * PB + a]) bad++;
      chk(len > PB ? "R4" : "R6", bad, 0);
      wp = 1'b0;
   endtask

   initial begin
      #(5ns * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int lens[5] = '{0, 1, 5, 16, 19};
      int pages[2] = '{3, 12};
      for (int a = 0; a < 256; a++) begin exp_mem[a] = '0; got_mem[a] = '0; end
      rst_n = 1'b0; txn_start = 0; byte_vld = 0; stop_evt = 0; wp = 0;
      start_addr = '0; byte_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", busy, 0); chk("R1", byte_ack, 0); chk("R1", arr_we, 0); chk("R1", ptr_out, 0);

      for (int w = 0; w < 2; w++)
         for (int p = 0; p < 2; p++)
            for (int s = 0; s < PB; s++)
               for (int l = 0; l < 5; l++)
                  run_txn(pages[p], s, lens[l], w[0]);

      // R10: strobes during busy are ignored
      run_txn(2, 3, 2, 1'b0);
      @(negedge clk); txn_start = 1'b1; start_addr = 8'h25;
      @(negedge clk); txn_start = 1'b0;
      byte_vld = 1'b1; byte_data = 8'h11;
      @(negedge clk); byte_vld = 1'b0;
      stop_evt = 1'b1;
      @(negedge clk); stop_evt = 1'b0;
      chk("R10", busy, 1);
      start_addr = 8'hF0; txn_start = 1'b1;
      @(negedge clk); txn_start = 1'b0;
      byte_vld = 1'b1; byte_data = 8'h77;
      @(negedge clk); byte_vld = 1'b0;
      chk("R10", byte_ack, 0);
      chk("R10", ptr_out, 8'h26);
      stop_evt = 1'b1;
      @(negedge clk); stop_evt = 1'b0;
      chk("R10", ptr_out, 8'h26);
      repeat (TWR + 4) @(negedge clk);
      chk("R10", busy, 0);
      chk("R10", got_mem[8'h25], 8'h11);
      chk("R10", got_mem[8'hF0], exp_mem[8'hF0]);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule